// File: doc/BRIEF.md
# Strap-Configurable Chip-Select-Gated Registered Buffer

This block is a clocked register bank for the address and command path of a memory module. A strap input chooses between two modes. In the wide mode, 25 inputs each drive one output one clock later. In the duplicating mode, 14 inputs are each registered once and placed on two outputs. A second strap chooses which 14 inputs feed the duplicating mode: the low group or the high group.

Two active-low chip-select inputs let the bank save power. While both are high, the data outputs keep their previous value. The chip selects are also registered onto an output of their own, and that output updates on every edge. An asynchronous active-low reset clears all state at once. It is released through a two-stage synchronizer.

Both straps must stay fixed while the block is in operation. To change them, hold reset low. The bank has no flow control. Every rising edge is a capture opportunity, so the stream-style valid/ready handshake is not used here.

Top module: `rb_top`

## Requirements
- R1: With `mode_dup`=0, `q_out[i]` equals `d_in[i]` for i = 0 to 24, as captured at the previous enabled rising edge.
- R2: With `mode_dup`=0, the spare outputs `q_out[27:25]` are always 0.
- R3: With `mode_dup`=1 and `dup_upper`=0, `q_out[13:0]` and `q_out[27:14]` both equal the captured `d_in[13:0]`.
- R4: With `mode_dup`=1 and `dup_upper`=1, `q_out[13:0]` and `q_out[27:14]` both equal the captured `d_in[24:11]`.
- R5: Data are captured on the rising edge of `clk` and appear on `q_out` right after that edge, with a latency of one edge.
- R6: At an edge where both bits of `cs_n` are 1, `q_out` keeps its previous value.
- R7: At an edge where either bit of `cs_n` is 0, `q_out` loads the routed input.
- R8: `cs_q_n` takes the value of `cs_n` at every rising edge, whatever the gating.
- R9: When `rst_n` goes low, `q_out` and `cs_q_n` become 0 at once, without waiting for a clock edge.
- R10: Reset takes priority over chip-select gating. While `rst_n` is low, clock edges with chip selects active leave every output at 0.
- R11: Reset release is synchronous. After `rst_n` rises, the first two rising edges change nothing, and the third rising edge is the first that captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dup | input | 1 | Strap: 0 = 25-bit 1:1, 1 = 14-bit 1:2 |
| dup_upper | input | 1 | Strap: in 1:2 mode, 0 = low input group, 1 = high input group |
| cs_n | input | 2 | Active-low chip selects; outputs hold while both are 1 |
| d_in | input | 25 | Data inputs |
| q_out | output | 28 | Registered data outputs |
| cs_q_n | output | 2 | Registered chip selects |

## Verification
The bench sweeps all four strap combinations. For each one it checks every chip-select combination, walking-one patterns and pseudo-random words.

- A routing error shows up as a copy placed on the wrong bit, a mismatch between the two halves in 1:2 mode, or the wrong input group feeding 1:2 mode.
- A spare output that leaks data in wide mode shows up as a nonzero value on `q_out[27:25]`.
- Wrong gating shows up as a load while both selects are high, a hold while only one is low, or a chip-select register that is wrongly gated along with the data.
- A reset fault shows up as a reset mid-run that does not clear the outputs at once, an edge during reset that captures data, or a release that captures one edge too early or too late.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    RM_WIDE     = 2'd0,
    RM_DUP_LOW  = 2'd1,
    RM_DUP_HIGH = 2'd2
  } route_mode_e;

  function automatic route_mode_e decode_straps(input logic dup, input logic upper);
    if (!dup)      return RM_WIDE;
    else if (upper) return RM_DUP_HIGH;
    else            return RM_DUP_LOW;
  endfunction

endpackage

// File: rtl/rb_reset_sync.sv
module rb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/rb_route.sv
module rb_route
  import rb_pkg::*;
#(
  parameter int WIDE_W = 25,
  parameter int DUP_W  = 14
) (
  input  route_mode_e           mode,
  input  logic [WIDE_W-1:0]     d,
  output logic [2*DUP_W-1:0]    r
);
  localparam int OUT_W  = 2 * DUP_W;
  localparam int HI_OFF = WIDE_W - DUP_W;

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    localparam int SRC = k % DUP_W;
    logic wide_bit;
    if (k < WIDE_W) begin : g_w
      assign wide_bit = d[k];
    end else begin : g_spare
      assign wide_bit = 1'b0;
    end
    always_comb begin
      unique case (mode)
        RM_DUP_LOW:  r[k] = d[SRC];
        RM_DUP_HIGH: r[k] = d[SRC + HI_OFF];
        default:     r[k] = wide_bit;
      endcase
    end
  end
endmodule

// File: rtl/rb_gate_reg.sv
module rb_gate_reg #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         load,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q <= '0;
    else if (load)   q <= nxt;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load |=> $stable(q));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (q == $past(nxt)));
endmodule

// File: rtl/rb_top.sv
module rb_top
  import rb_pkg::*;
#(
  parameter int WIDE_W      = 25,
  parameter int DUP_W       = 14,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_W       = 2 * DUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dup,
  input  logic              dup_upper,
  input  logic [1:0]        cs_n,
  input  logic [WIDE_W-1:0] d_in,
  output logic [OUT_W-1:0]  q_out,
  output logic [1:0]        cs_q_n
);
  logic        rst_sync_n;
  route_mode_e mode;
  logic [OUT_W-1:0] routed;
  logic        load;

  rb_reset_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign mode = decode_straps(mode_dup, dup_upper);

  rb_route #(.WIDE_W(WIDE_W), .DUP_W(DUP_W)) i_route (
    .mode(mode), .d(d_in), .r(routed)
  );

  assign load = ~&cs_n;

  rb_gate_reg #(.W(OUT_W)) i_data (
    .clk(clk), .rst_sync_n(rst_sync_n), .load(load), .nxt(routed), .q(q_out)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cs_q_n <= '0;
    else             cs_q_n <= cs_n;
  end

  // R2
  wide_spare_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mode_dup |-> (q_out[OUT_W-1:WIDE_W] == '0));

  // R3
  dup_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_dup |-> (q_out[DUP_W-1:0] == q_out[OUT_W-1:DUP_W]));

  // R8
  cs_track_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (cs_q_n == $past(cs_n)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (q_out == '0 && cs_q_n == '0));
endmodule

// File: tb/test_rb_top.sv
`timescale 1ns/1ps
module test_rb_top;
  localparam int WW = 25;
  localparam int DW = 14;
  localparam int OW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_dup, dup_upper;
  logic [1:0] cs_n;
  logic [WW-1:0] d_in;
  logic [OW-1:0] q_out;
  logic [1:0] cs_q_n;

  int checks = 0;
  int fails  = 0;
  logic [OW-1:0] exp_q;
  logic [1:0]    exp_cs;

  always #2.5 clk = ~clk;

  rb_top i_rb_top (
    .clk(clk), .rst_n(rst_n), .mode_dup(mode_dup), .dup_upper(dup_upper),
    .cs_n(cs_n), .d_in(d_in), .q_out(q_out), .cs_q_n(cs_q_n)
  );

  function automatic logic [OW-1:0] ref_route(input logic [WW-1:0] d, input logic dup,
                                              input logic up);
    logic [OW-1:0] r;
    for (int k = 0; k < OW; k++) begin
      if (!dup) r[k] = (k < WW) ? d[k] : 1'b0;
      else      r[k] = d[(k % DW) + (up ? (WW - DW) : 0)];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [OW-1:0] exq, input logic [1:0] exc);
    checks++;
    if (q_out !== exq || cs_q_n !== exc) begin
      fails++;
      $display("FAIL %s q=%h exp=%h cs=%b exp=%b", req, q_out, exq, cs_q_n, exc);
    end
  endtask

  // called at a falling edge; drives, clocks, updates model, checks
  task automatic cyc(input logic [WW-1:0] d, input logic [1:0] cs, input string req);
    d_in = d;
    cs_n = cs;
    @(posedge clk);
    #1;
    if (cs != 2'b11) exp_q = ref_route(d, mode_dup, dup_upper);
    exp_cs = cs;
    chk(req, exp_q, exp_cs);
    @(negedge clk);
  endtask

  // reset with the given straps, then release; checks R11 timing
  task automatic do_reset(input logic dup, input logic up);
    logic [WW-1:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    mode_dup = dup;
    dup_upper = up;
    cs_n = 2'b00;
    d_in = 25'h1ABCDEF;
    #1;
    chk("R9", '0, 2'b00);
    @(negedge clk);
    // R10: edges during reset with chip selects active change nothing
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      chk("R10", '0, 2'b00);
      @(negedge clk);
    end
    d = 25'h0F0F0F5 ^ {24'd0, dup} ^ {23'd0, up, 1'b0};
    d_in = d;
    rst_n = 1'b1;
    // R11: first two edges after release capture nothing
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      chk("R11", '0, 2'b00);
      @(negedge clk);
    end
    @(posedge clk); #1;
    exp_q = ref_route(d, dup, up);
    exp_cs = 2'b00;
    chk("R11", exp_q, exp_cs);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_dup = 1'b0;
    dup_upper = 1'b0;
    cs_n = 2'b11;
    d_in = '0;
    exp_q = '0;
    exp_cs = '0;
    #1;
    chk("R9", '0, 2'b00);
    for (int m = 0; m < 4; m++) begin
      logic dup, up;
      string rq;
      dup = m[1];
      up = m[0];
      rq = !dup ? "R1" : (up ? "R4" : "R3");
      do_reset(dup, up);
      // walking one through every input, chip selects active (R5)
      for (int b = 0; b < WW; b++) cyc(25'd1 << b, 2'(b % 3), rq);
      // every chip-select combination with distinct data
      for (int c = 0; c < 4; c++) begin
        cyc($urandom, 2'b00, "R7");
        cyc($urandom, 2'(c), (c == 3) ? "R6" : "R7");
        cyc($urandom, 2'b11, "R6");
        cyc($urandom, 2'b11, "R8");
        cyc($urandom, 2'(c), "R8");
      end
      // random data sweep
      for (int i = 0; i < 40; i++) cyc($urandom, 2'($urandom), rq);
      // spare outputs in wide mode
      if (!dup) begin
        cyc('1, 2'b10, "R2");
        checks++;
        if (q_out[OW-1:WW] !== '0) begin
          fails++;
          $display("FAIL R2 spare=%b exp=000", q_out[OW-1:WW]);
        end
      end
      // mid-operation asynchronous reset
      cyc('1, 2'b01, rq);
      #0.7;
      rst_n = 1'b0;
      #0.3;
      chk("R9", '0, 2'b00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule